// File: doc/BRIEF.md
# SDRAM Power-Down Sequencer

This block owns the clock-enable pin of a DDR SDRAM for its low-power standby states. A scheduler raises a level request when it wants the device parked. The block brings clock enable low only while no burst is running. It records which standby flavour the device is in: active standby when at least one bank still holds an open row, precharge standby when every bank is idle.

When the request is withdrawn and the minimum dwell has elapsed, the block raises clock enable again. It then reserves the following cycle as a mandatory no-operation slot. Other command sources are told to stay quiet from entry until that slot has passed.

A request raised during a burst simply waits. It is taken on the first cycle with no burst if it is still present.

Top module: `sdram_pd_ctrl`

## Requirements
- R1: Out of reset cke_o is 1, and pd_active_o, pd_mode_o, nop_force_o and cmd_block_o are all 0.
- R2: When cke_o is 1 and no wake slot is in progress, a clock edge that sees pd_req_i=1 and burst_busy_i=0 drives cke_o to 0 and pd_active_o to 1 from the next cycle.
- R3: While burst_busy_i is 1, cke_o does not fall, whatever pd_req_i does.
- R4: A request held across a burst is taken on the first edge with burst_busy_i=0 if pd_req_i is still 1. If pd_req_i has dropped by then, power-down is not entered.
- R5: pd_mode_o takes the value of banks_idle_i sampled at the entry edge (1 = precharge standby, 0 = active standby). It stays fixed during power-down and the wake slot, whatever banks_idle_i does.
- R6: Once low, cke_o stays low for at least MIN_PD_CYC consecutive cycles.
- R7: With pd_req_i dropped during low cycle k (counting from 1), cke_o rises after low cycle max(MIN_PD_CYC, k).
- R8: In the first cycle with cke_o back at 1, nop_force_o is 1. It is 0 in every other cycle.
- R9: cmd_block_o is 1 exactly in the cycles where cke_o is 0 and in the wake slot.
- R10: After the wake slot, cke_o stays 1 for at least one more cycle even if pd_req_i is already 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_req_i | input | 1 | Level request to enter and remain in power-down |
| burst_busy_i | input | 1 | A read or write burst is in progress |
| banks_idle_i | input | 1 | All banks are precharged |
| cke_o | output | 1 | Clock enable to the memory |
| pd_active_o | output | 1 | Device is in power-down |
| pd_mode_o | output | 1 | Mode latched at entry: 1 precharge standby, 0 active standby |
| nop_force_o | output | 1 | Command slot must carry a NOP |
| cmd_block_o | output | 1 | Other command sources must stay idle |

## Verification
The assertions check the following on every cycle:
- no falling edge of clock enable unless the previous edge saw a request with no burst;
- the mode stays fixed while parked;
- a wake slot follows every rise of clock enable and lasts one cycle;
- command blocking covers every low cycle;
- a wake only follows a finished dwell.

Some properties can only be shown by the bench's scenarios, because they depend on the cycle at which the request is released. These are:
- the exact low duration max(MIN_PD_CYC, k) over a sweep of release points;
- the pending-request behaviour across bursts of several lengths, including a request withdrawn before the burst ends;
- the forced idle cycle before re-entry.

// File: rtl/sdram_pd_pkg.sv
package sdram_pd_pkg;
  typedef enum logic [1:0] {
    PD_RUN   = 2'd0,
    PD_SLEEP = 2'd1,
    PD_WAKE  = 2'd2
  } pd_state_e;
endpackage

// File: rtl/pd_dwell_cnt.sv
module pd_dwell_cnt #(
  parameter int unsigned MIN_PD_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic done_o
);
  localparam int unsigned CNT_W = (MIN_PD_CYC > 1) ? $clog2(MIN_PD_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_PD_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (en_i && !done_o)  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LAST);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R6
endmodule

// File: rtl/pd_fsm.sv
module pd_fsm
  import sdram_pd_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      req_i,
  input  logic      busy_i,
  input  logic      dwell_done_i,
  output logic      enter_o,
  output pd_state_e state_o
);
  pd_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    enter_o = 1'b0;
    unique case (state_q)
      PD_RUN: if (req_i && !busy_i) begin
        state_d = PD_SLEEP;
        enter_o = 1'b1;
      end
      PD_SLEEP: if (!req_i && dwell_done_i) state_d = PD_WAKE;
      PD_WAKE:  state_d = PD_RUN;  // mandatory NOP slot, no re-entry
      default:  state_d = PD_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PD_RUN;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  AST_WAKE_AFTER_DWELL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PD_SLEEP && state_d == PD_WAKE) |-> dwell_done_i); // R6
  AST_WAKE_TO_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PD_WAKE) |=> (state_q == PD_RUN)); // R10
endmodule

// File: rtl/pd_mode_latch.sv
module pd_mode_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic idle_i,
  output logic mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mode_o <= 1'b0;
    else if (load_i) mode_o <= idle_i;
  end
endmodule

// File: rtl/sdram_pd_ctrl.sv
module sdram_pd_ctrl
  import sdram_pd_pkg::*;
#(
  parameter int unsigned MIN_PD_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_req_i,
  input  logic burst_busy_i,
  input  logic banks_idle_i,
  output logic cke_o,
  output logic pd_active_o,
  output logic pd_mode_o,
  output logic nop_force_o,
  output logic cmd_block_o
);
  pd_state_e state;
  logic      enter;
  logic      dwell_done;

  pd_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (pd_req_i),
    .busy_i       (burst_busy_i),
    .dwell_done_i (dwell_done),
    .enter_o      (enter),
    .state_o      (state)
  );

  pd_dwell_cnt #(.MIN_PD_CYC(MIN_PD_CYC)) u_dwell (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state != PD_SLEEP),
    .en_i   (state == PD_SLEEP),
    .done_o (dwell_done)
  );

  pd_mode_latch u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (enter),
    .idle_i (banks_idle_i),
    .mode_o (pd_mode_o)
  );

  assign cke_o       = (state != PD_SLEEP);
  assign pd_active_o = (state == PD_SLEEP);
  assign nop_force_o = (state == PD_WAKE);
  assign cmd_block_o = (state != PD_RUN);

  AST_ENTRY_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> $past(pd_req_i && !burst_busy_i)); // R3
  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_block_o && $past(cmd_block_o)) |-> $stable(pd_mode_o)); // R5
  AST_NOP_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> nop_force_o); // R8
  AST_NOP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nop_force_o |=> !nop_force_o); // R8
  AST_BLOCK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> cmd_block_o); // R9
endmodule

// File: tb/sim_sdram_pd_ctrl.sv
module sim_sdram_pd_ctrl;
  localparam int unsigned MIN_PD = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, busy = 1'b0, idle = 1'b0;
  logic cke, act, mode, nop, blk;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  sdram_pd_ctrl #(.MIN_PD_CYC(MIN_PD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pd_req_i(req), .burst_busy_i(busy),
    .banks_idle_i(idle), .cke_o(cke), .pd_active_o(act), .pd_mode_o(mode),
    .nop_force_o(nop), .cmd_block_o(blk)
  );

  task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0d exp=%0d t=%0t", r, got, exp, $time);
    end
  endtask

  // enter, drop request in low cycle hold+1, measure low length
  task automatic park(input int hold, input logic idl);
    int low;
    @(negedge clk); req = 1'b1; idle = idl;
    @(negedge clk);
    chk("R2 cke", cke, 0); chk("R2 act", act, 1); chk("R5 mode", mode, idl);
    low = 0;
    for (int k = 1; k <= 40; k++) begin
      if (cke) break;
      low++;
      chk("R9 blk", blk, 1); chk("R8 nop", nop, 0);
      chk("R5 held", mode, idl);
      idle = ~idle;
      req = (k < hold + 1);
      @(negedge clk);
    end
    chk("R7 len", low, (hold + 1 > MIN_PD) ? hold + 1 : MIN_PD);
    chk("R6 min", low >= MIN_PD, 1);
    chk("R8 nop", nop, 1); chk("R9 blk", blk, 1); chk("R5 wake", mode, idl);
    @(negedge clk);
    chk("R8 off", nop, 0); chk("R9 off", blk, 0); chk("R10 cke", cke, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cke", cke, 1); chk("R1 act", act, 0); chk("R1 mode", mode, 0);
    chk("R1 nop", nop, 0); chk("R1 blk", blk, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle", cke, 1);

    for (int h = 0; h <= 6; h++)
      for (int i = 0; i <= 1; i++) park(h, logic'(i));

    // R3 / R4: request pending through bursts
    for (int b = 1; b <= 5; b++) begin
      @(negedge clk); busy = 1'b1; req = 1'b1; idle = 1'b0;
      for (int c = 0; c < b; c++) begin
        @(negedge clk); chk("R3 busy", cke, 1);
        req = (c % 2 == 0);
        req = 1'b1;
      end
      busy = 1'b0; idle = 1'b1;
      @(negedge clk);
      chk("R4 taken", cke, 0); chk("R5 mode", mode, 1);
      req = 1'b0;
      repeat (MIN_PD) @(negedge clk);
      chk("R8 nop", nop, 1);
      @(negedge clk);
    end
    // R4: request withdrawn before burst ends
    @(negedge clk); busy = 1'b1; req = 1'b1;
    repeat (3) @(negedge clk);
    req = 1'b0;
    @(negedge clk); busy = 1'b0;
    repeat (3) begin @(negedge clk); chk("R4 dropped", cke, 1); chk("R9 run", blk, 0); end

    // R10: request back during wake slot
    @(negedge clk); req = 1'b1; idle = 1'b0;
    @(negedge clk); chk("R2 cke", cke, 0); chk("R5 act", mode, 0);
    req = 1'b0;
    repeat (MIN_PD - 1) @(negedge clk);
    @(negedge clk); chk("R8 slot", nop, 1);
    req = 1'b1;
    @(negedge clk); chk("R10 gap", cke, 1); chk("R10 nop", nop, 0);
    @(negedge clk); chk("R10 reenter", cke, 0);
    req = 1'b0;
    repeat (MIN_PD + 2) @(negedge clk);
    chk("R7 back", cke, 1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); n_run++; n_fail++;
        $display("FAIL watchdog got=0 exp=1"); end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule